// File: doc/BRIEF.md
# Cascadable Range Counter

This block is a synchronous up-counter built by chaining identical narrow counting slices. Each slice holds a few bits and has a synchronous clear, a synchronous load, a count enable and a carry output. A slice's carry feeds the enable of the next slice up. With the default parameters, two 4-bit slices form an 8-bit counter.

A shared wrap controller watches the whole count and decides when the sequence folds back. It has four policies:
- free running, which rolls over from all ones to zero;
- reload a start value after the all-ones state;
- clear to zero when the count equals an end value;
- combined, which reloads the start value when the count equals the end value or reaches all ones.

Every wrap action is a step of the count, so it only happens on a cycle where the enable is high. Reset is synchronous and active low.

Top module: `casc_range_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0 after that edge.
- R2: With `en` low the count holds its value. With `en` high and no wrap action, it rises by one per edge. In free mode (`mode_sel` = 2'b00) it rolls from 8'hFF to 8'h00.
- R3: `carry_o` is high exactly while `en` is high and the count is all ones (8'hFF). It is combinational from the count and `en`.
- R4: A higher slice advances only on an edge where every lower slice is all ones and `en` is high. The upper nibble therefore goes from 0 to 1 on the step from 8'h0F to 8'h10.
- R5: In start mode (`mode_sel` = 2'b01), an enabled step from 8'hFF loads `start_val`. Other enabled steps increment.
- R6: In end mode (`mode_sel` = 2'b10), an enabled step from a count equal to `end_val` clears the count to 0. Other enabled steps increment. Clear takes precedence over load inside each slice, and load takes precedence over counting.
- R7: In combined mode (`mode_sel` = 2'b11), an enabled step from a count equal to `end_val`, or from 8'hFF, loads `start_val`. If `end_val` is below `start_val`, the count therefore runs from the start value up through all ones and reloads there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable for the whole chain |
| mode_sel | input | 2 | Wrap policy: 00 free, 01 start reload, 10 end clear, 11 combined |
| start_val | input | STAGES*W | Value loaded on a start-type wrap |
| end_val | input | STAGES*W | Count value that triggers an end-type wrap |
| count_o | output | STAGES*W | Current count |
| carry_o | output | 1 | High while enabled at all ones; used to chain further counters |

## Verification
Each new count value is due one rising edge after the inputs that cause it. The bench therefore drives its inputs just after a falling edge, lets one rising edge pass, and compares `count_o` at the following falling edge. `carry_o` is due in the same cycle that `en` and the count settle, with no register in between. For that reason it is compared one time unit after the inputs change, before the next rising edge. A bench model advances its own count on the same edge, using a plain case on the policy, and every compare is taken against that model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    WRAP_FREE  = 2'b00,
    WRAP_START = 2'b01,
    WRAP_END   = 2'b10,
    WRAP_RANGE = 2'b11
  } wrap_mode_e;

endpackage

// File: rtl/cnt_slice.sv
// One narrow counting slice: sync clear > sync load > count.
module cnt_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         sclr,
  input  logic         sld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         rc_o
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (sclr)        q_nxt = '0;
    else if (sld)    q_nxt = ld_val;
    else if (cnt_en) q_nxt = incr(q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // AND of the enable and every stored bit
  assign rc_o = cnt_en & (q == ONES);

endmodule

// File: rtl/cnt_wrap_ctl.sv
// Decides when the full-width count folds back to zero or to the start value.
module cnt_wrap_ctl #(
  parameter int TW = 8
) (
  input  cnt_pkg::wrap_mode_e mode,
  input  logic                adv,
  input  logic                top_carry,
  input  logic [TW-1:0]       count,
  input  logic [TW-1:0]       end_val,
  output logic                wr_clr,
  output logic                wr_ld
);
  import cnt_pkg::*;

  function automatic logic hits_end(input logic [TW-1:0] c,
                                    input logic [TW-1:0] e);
    return c == e;
  endfunction

  logic at_end;
  assign at_end = adv & hits_end(count, end_val);

  always_comb begin
    wr_clr = 1'b0;
    wr_ld  = 1'b0;
    unique case (mode)
      WRAP_START: wr_ld  = top_carry;
      WRAP_END:   wr_clr = at_end;
      WRAP_RANGE: wr_ld  = at_end | top_carry;
      default: ;
    endcase
  end

endmodule

// File: rtl/casc_range_counter.sv
module casc_range_counter #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  localparam int TW    = W * STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode_sel,
  input  logic [TW-1:0] start_val,
  input  logic [TW-1:0] end_val,
  output logic [TW-1:0] count_o,
  output logic          carry_o
);
  import cnt_pkg::*;

  // named internal events, observed by the bound checker
  logic              wrap_clr;
  logic              wrap_ld;
  logic [STAGES:0]   chain;
  wrap_mode_e        mode;

  assign mode     = wrap_mode_e'(mode_sel);
  assign chain[0] = en;
  assign carry_o  = chain[STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_slice
    cnt_slice #(.W(W)) slice_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (chain[g]),
      .sclr   (wrap_clr),
      .sld    (wrap_ld),
      .ld_val (start_val[g*W +: W]),
      .q      (count_o[g*W +: W]),
      .rc_o   (chain[g+1])
    );
  end

  cnt_wrap_ctl #(.TW(TW)) wrap_i (
    .mode      (mode),
    .adv       (en),
    .top_carry (carry_o),
    .count     (count_o),
    .end_val   (end_val),
    .wr_clr    (wrap_clr),
    .wr_ld     (wrap_ld)
  );

endmodule

// File: rtl/casc_range_counter_chk.sv
module casc_range_counter_chk #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  localparam int TW    = W * STAGES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [1:0]        mode_sel,
  input logic [TW-1:0]     start_val,
  input logic [TW-1:0]     end_val,
  input logic [TW-1:0]     count_o,
  input logic              carry_o,
  input logic              wrap_clr,
  input logic              wrap_ld,
  input logic [STAGES-1:0] stage_en
);
  import cnt_pkg::*;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count_o));

  a_r3_carry_full: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (en && (&count_o)));

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    a_r4_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_en[g] && !wrap_clr && !wrap_ld) |=> $stable(count_o[g*W +: W]));
  end

  a_r5_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == WRAP_START && carry_o) |=> count_o == $past(start_val));

  a_r6_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == WRAP_END && en && count_o == end_val) |=> count_o == '0);

  a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_clr && wrap_ld));

  a_r7_range_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == WRAP_RANGE && en && (count_o == end_val || (&count_o)))
      |=> count_o == $past(start_val));

endmodule

bind casc_range_counter casc_range_counter_chk #(.W(W), .STAGES(STAGES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .mode_sel  (mode_sel),
  .start_val (start_val),
  .end_val   (end_val),
  .count_o   (count_o),
  .carry_o   (carry_o),
  .wrap_clr  (wrap_clr),
  .wrap_ld   (wrap_ld),
  .stage_en  (chain[STAGES-1:0])
);

// File: tb/casc_range_counter_tb_top.sv
module casc_range_counter_tb_top;

  logic       clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] st = 8'h00;
  logic [7:0] ed = 8'h00;
  logic [7:0] cnt;
  logic       cy;

  int total = 0;
  int bad   = 0;
  logic [7:0] model = 8'h00;

  casc_range_counter dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode),
    .start_val(st), .end_val(ed), .count_o(cnt), .carry_o(cy)
  );

  typedef struct packed {
    logic       r;
    logic       e;
    logic [1:0] m;
    logic [7:0] s;
    logic [7:0] d;
    logic [15:0] n;
  } seg_t;

  localparam int NSEG = 10;
  localparam seg_t SEGS [NSEG] = '{
    '{1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'd3},
    '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 16'd300},
    '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 16'd5},
    '{1'b1, 1'b1, 2'd1, 8'h60, 8'h00, 16'd400},
    '{1'b1, 1'b1, 2'd2, 8'h00, 8'hD3, 16'd500},
    '{1'b1, 1'b1, 2'd3, 8'h20, 8'h40, 16'd200},
    '{1'b1, 1'b1, 2'd3, 8'hC0, 8'h30, 16'd600},
    '{1'b1, 1'b1, 2'd2, 8'h00, 8'hFF, 16'd300},
    '{1'b0, 1'b1, 2'd1, 8'h10, 8'h00, 16'd2},
    '{1'b1, 1'b1, 2'd1, 8'hF0, 8'h00, 16'd100}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock step: drive, check carry, pass an edge, check count
  task automatic step(input logic r, input logic e, input logic [1:0] m,
                      input logic [7:0] s, input logic [7:0] d);
    string tag;
    rst_n = r; en = e; mode = m; st = s; ed = d;
    #1;
    check("R3", {7'd0, cy}, {7'd0, (e && model == 8'hFF)});
    @(posedge clk);
    if (!r) begin
      model = 8'h00; tag = "R1";
    end else if (!e) begin
      tag = "R2";
    end else begin
      case (m)
        2'd1: if (model == 8'hFF) begin model = s; tag = "R5"; end
              else begin model = model + 8'd1; tag = "R5"; end
        2'd2: if (model == d) begin model = 8'h00; tag = "R6"; end
              else begin model = model + 8'd1; tag = "R6"; end
        2'd3: if (model == d || model == 8'hFF) begin model = s; tag = "R7"; end
              else begin model = model + 8'd1; tag = "R7"; end
        default: begin model = model + 8'd1; tag = "R4"; end
      endcase
    end
    @(negedge clk);
    check(tag, cnt, model);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step(1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    step(1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    check("R1", cnt, 8'h00);

    // R4: cascade into the upper slice
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
    check("R4", cnt, 8'h0F);
    step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
    check("R4", cnt, 8'h10);
    for (int i = 0; i < 239; i++) step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
    check("R2", cnt, 8'hFF);

    // R3: carry follows the enable at all ones
    en = 1'b1; #1; check("R3", {7'd0, cy}, 8'h01);
    en = 1'b0; #1; check("R3", {7'd0, cy}, 8'h00);
    @(negedge clk);
    step(1'b1, 1'b0, 2'd0, 8'h00, 8'h00);
    check("R2", cnt, 8'hFF);
    step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
    check("R2", cnt, 8'h00);

    // R5: start reload after all ones
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1, 2'd1, 8'h06, 8'h00);
    check("R5", cnt, 8'hFF);
    step(1'b1, 1'b1, 2'd1, 8'h06, 8'h00);
    check("R5", cnt, 8'h06);

    // R6: end clear
    step(1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    for (int i = 0; i < 13; i++) step(1'b1, 1'b1, 2'd2, 8'h00, 8'h0D);
    check("R6", cnt, 8'h0D);
    step(1'b1, 1'b1, 2'd2, 8'h00, 8'h0D);
    check("R6", cnt, 8'h00);

    // R7: combined range
    step(1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    for (int i = 0; i < 34; i++) step(1'b1, 1'b1, 2'd3, 8'h20, 8'h22);
    check("R7", cnt, 8'h22);
    step(1'b1, 1'b1, 2'd3, 8'h20, 8'h22);
    check("R7", cnt, 8'h20);
    step(1'b1, 1'b1, 2'd3, 8'h20, 8'h22);
    step(1'b1, 1'b1, 2'd3, 8'h20, 8'h22);
    step(1'b1, 1'b1, 2'd3, 8'h20, 8'h22);
    check("R7", cnt, 8'h20);

    // table-driven segments checked against the model every cycle
    for (int k = 0; k < NSEG; k++) begin
      for (int i = 0; i < int'(SEGS[k].n); i++)
        step(SEGS[k].r, SEGS[k].e, SEGS[k].m, SEGS[k].s, SEGS[k].d);
    end

    finish_run();
  end

endmodule